// File: doc/BRIEF.md
# Floating-Point Control and Exception Flag Unit

This block holds the control and status state that a small processor keeps for its floating-point operations. When an operation launches, it turns the stored 2-bit rounding field into a one-hot rounding select for the arithmetic units. It holds that select for the whole operation and clears the per-operation exception record. When the operation retires, the arithmetic units report a 5-bit exception vector. The block records that vector and merges it into sticky flags.

A trap is requested only for a flag that this retirement turns from 0 to 1 while its enable bit is set. An exception that is already flagged stays quiet. Software reads the rounding field, flags and enables back directly and can overwrite them through a small register-write port.

A two-state sequencer tracks whether an operation is in flight. It has two states. `SEQ_IDLE` means no operation is open, and `SEQ_BUSY` means one is. The LAUNCH transition goes from `SEQ_IDLE` to `SEQ_BUSY` on a start strobe. The RETIRE transition goes from `SEQ_BUSY` back to `SEQ_IDLE` on an end strobe. A strobe that does not match the current state causes no transition.

Top module: `fpsu_top`

## Requirements
- R1: After reset, the rounding field, flags, enables, per-operation record, trap output and trap cause are all 0, the one-hot select is 4'b0001, and the sequencer is idle.
- R2: On LAUNCH, the one-hot select becomes 1 << field. The field encoding is 0 nearest-even, 1 toward zero, 2 toward minus infinity and 3 toward plus infinity. A later write to the field does not change the select until the next LAUNCH.
- R3: The per-operation exception record (`op_exc_o`) is 0 after LAUNCH and holds the retiring exception vector after RETIRE.
- R4: At RETIRE, every raised exception sets its sticky flag. The exception bits are 0 inexact, 1 divide-by-zero, 2 invalid, 3 overflow and 4 underflow. Retirement never clears a flag.
- R5: A trap is requested exactly for the flags that go from 0 to 1 at this RETIRE and whose enable bit is 1. `trap_cause_o` names those bits.
- R6: A raised exception whose flag is already set changes nothing and requests no trap.
- R7: A RETIRE with an all-zero exception vector leaves all flags unchanged and requests no trap.
- R8: `trap_o` is a one-cycle pulse in the cycle after the end strobe.
- R9: A flag write (`wr_sel_i` = 1) in the same cycle as RETIRE wins. The flags take the written value and no trap is requested.
- R10: An end strobe while idle is ignored and leaves flags, record and trap output unchanged. A start strobe while busy is ignored.
- R11: Register writes select the target by `wr_sel_i`: 0 rounding field (`wr_data_i[1:0]`), 1 flags, 2 enables, 3 nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start_i | input | 1 | Operation start strobe |
| op_end_i | input | 1 | Operation end strobe |
| op_exc_i | input | 5 | Exceptions raised by the retiring operation |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 field, 1 flags, 2 enables, 3 none |
| wr_data_i | input | 5 | Write data |
| rnd_mode_o | output | 2 | Stored rounding field |
| rnd_onehot_o | output | 4 | One-hot rounding select latched at launch |
| op_busy_o | output | 1 | Operation in flight |
| op_exc_o | output | 5 | Per-operation exception record |
| flags_o | output | 5 | Sticky exception flags |
| enables_o | output | 5 | Trap enable bits |
| trap_o | output | 1 | Trap request pulse |
| trap_cause_o | output | 5 | Flags that caused the trap |

## Verification
The merge function is driven from a table. Each row first preloads flags and enables and then retires one operation with a chosen exception vector. The rows cover these cases:
- all flags clear with traps disabled, which separates flag setting from trap requests;
- a single enabled new exception;
- an exception whose flag is already set;
- a mix of fresh and stale bits under a partial enable mask, which shows that the trap compares against the old flags;
- all five raised at once under a sparse enable mask;
- empty vectors over clear and over populated flags.

Directed cases then step through the four rounding encodings, check that a mid-operation field write does not alter the select, check the per-operation record clearing, and exercise a strobe in the wrong state, a write racing a retirement, and the width of the trap pulse.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;

    localparam int EXC_W = 5;
    localparam int RND_W = 2;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_DOWN      = 2'd2,
        RM_UP        = 2'd3
    } rnd_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        WS_MODE   = 2'd0,
        WS_FLAGS  = 2'd1,
        WS_ENABLE = 2'd2,
        WS_NONE   = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/fpsu_seq.sv
module fpsu_seq
    import fpsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic end_i,
    output logic launch_o,
    output logic retire_o,
    output logic busy_o
);

    seq_state_e state_q, state_d;

    // next-state logic: LAUNCH and RETIRE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start_i) state_d = SEQ_BUSY;
            SEQ_BUSY: if (end_i)   state_d = SEQ_IDLE;
            default:               state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // output logic
    always_comb begin
        launch_o = 1'b0;
        retire_o = 1'b0;
        busy_o   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: launch_o = start_i;
            SEQ_BUSY: begin
                busy_o   = 1'b1;
                retire_o = end_i;
            end
            default: ;
        endcase
    end

    // R10: a launch always opens an operation, a retire always closes it
    a_r10_launch_opens: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> busy_o);
    a_r10_retire_closes: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> !busy_o);
    a_r10_idle_start_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/fpsu_round.sv
module fpsu_round
    import fpsu_pkg::*;
#(
    parameter int MODE_W = RND_W,
    localparam int SEL_N = 1 << MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_data_i,
    input  logic              launch_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [SEL_N-1:0]  onehot_o
);

    logic [MODE_W-1:0] mode_q;
    logic [SEL_N-1:0]  sel_q;
    logic [SEL_N-1:0]  sel_dec;

    // one decoder leg per rounding encoding
    for (genvar k = 0; k < SEL_N; k++) begin : g_dec
        assign sel_dec[k] = (mode_q == MODE_W'(k));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            sel_q  <= SEL_N'(1);
        end else begin
            if (mode_wr_i) mode_q <= mode_data_i;
            if (launch_i)  sel_q  <= sel_dec;
        end
    end

    assign mode_o   = mode_q;
    assign onehot_o = sel_q;

    // R2: select is always a single bit, follows the field at launch, held otherwise
    a_r2_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_q) == 1);
    a_r2_decode_at_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> (sel_q == (SEL_N'(1) << $past(mode_q))));
    a_r2_held_between: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_i |=> $stable(sel_q));

endmodule

// File: rtl/fpsu_flags.sv
module fpsu_flags
    import fpsu_pkg::*;
#(
    parameter int NEXC = EXC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch_i,
    input  logic            retire_i,
    input  logic [NEXC-1:0] exc_i,
    input  logic            flag_wr_i,
    input  logic            en_wr_i,
    input  logic [NEXC-1:0] wr_data_i,
    output logic [NEXC-1:0] flags_o,
    output logic [NEXC-1:0] enables_o,
    output logic [NEXC-1:0] op_exc_o,
    output logic            trap_o,
    output logic [NEXC-1:0] cause_o
);

    logic [NEXC-1:0] flags_q, en_q, rec_q, cause_q;
    logic            trap_q;
    logic [NEXC-1:0] fresh;     // flag goes 0 -> 1 now
    logic [NEXC-1:0] trap_bit;  // fresh and enabled
    logic            merge_ok;

    assign merge_ok = retire_i && !flag_wr_i;

    for (genvar b = 0; b < NEXC; b++) begin : g_bit
        assign fresh[b]    = exc_i[b] && !flags_q[b];
        assign trap_bit[b] = fresh[b] && en_q[b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            en_q    <= '0;
            rec_q   <= '0;
            cause_q <= '0;
            trap_q  <= 1'b0;
        end else begin
            if (en_wr_i) en_q <= wr_data_i;

            if (flag_wr_i)     flags_q <= wr_data_i;
            else if (retire_i) flags_q <= flags_q | fresh;

            if (launch_i)      rec_q <= '0;
            else if (retire_i) rec_q <= exc_i;

            trap_q  <= merge_ok && (|trap_bit);
            cause_q <= merge_ok ? trap_bit : '0;
        end
    end

    assign flags_o   = flags_q;
    assign enables_o = en_q;
    assign op_exc_o  = rec_q;
    assign trap_o    = trap_q;
    assign cause_o   = cause_q;

    // R3: record cleared by launch
    a_r3_clear_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> (rec_q == '0));
    // R4: without a software write no flag ever drops
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R5 / R6: a trap names only bits that were clear and are now set
    a_r5_cause_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (((cause_q & $past(flags_q)) == '0) && ((cause_q & flags_q) == cause_q)));
    a_r5_cause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o == (cause_q != '0));
    // R7: empty retirement is silent
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && (exc_i == '0) && !flag_wr_i) |=> ($stable(flags_q) && !trap_o));
    // R8: single-cycle pulse, only after a retirement
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);
    a_r8_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_i |=> !trap_o);
    // R9: software write wins over same-cycle merge
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_i |=> ((flags_q == $past(wr_data_i)) && !trap_o));

endmodule

// File: rtl/fpsu_top.sv
module fpsu_top
    import fpsu_pkg::*;
#(
    parameter int NEXC   = EXC_W,
    parameter int MODE_W = RND_W,
    localparam int SEL_N = 1 << MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic              op_end_i,
    input  logic [NEXC-1:0]   op_exc_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [NEXC-1:0]   wr_data_i,
    output logic [MODE_W-1:0] rnd_mode_o,
    output logic [SEL_N-1:0]  rnd_onehot_o,
    output logic              op_busy_o,
    output logic [NEXC-1:0]   op_exc_o,
    output logic [NEXC-1:0]   flags_o,
    output logic [NEXC-1:0]   enables_o,
    output logic              trap_o,
    output logic [NEXC-1:0]   trap_cause_o
);

    logic    launch, retire;
    logic    mode_wr, flag_wr, en_wr;
    wr_sel_e sel;

    // R11: write target decode
    always_comb begin
        sel     = wr_sel_e'(wr_sel_i);
        mode_wr = 1'b0;
        flag_wr = 1'b0;
        en_wr   = 1'b0;
        if (wr_en_i) begin
            unique case (sel)
                WS_MODE:   mode_wr = 1'b1;
                WS_FLAGS:  flag_wr = 1'b1;
                WS_ENABLE: en_wr   = 1'b1;
                WS_NONE:   ;
                default:   ;
            endcase
        end
    end

    fpsu_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (op_start_i),
        .end_i    (op_end_i),
        .launch_o (launch),
        .retire_o (retire),
        .busy_o   (op_busy_o)
    );

    fpsu_round #(.MODE_W(MODE_W)) u_round (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr_i   (mode_wr),
        .mode_data_i (wr_data_i[MODE_W-1:0]),
        .launch_i    (launch),
        .mode_o      (rnd_mode_o),
        .onehot_o    (rnd_onehot_o)
    );

    fpsu_flags #(.NEXC(NEXC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .retire_i  (retire),
        .exc_i     (op_exc_i),
        .flag_wr_i (flag_wr),
        .en_wr_i   (en_wr),
        .wr_data_i (wr_data_i),
        .flags_o   (flags_o),
        .enables_o (enables_o),
        .op_exc_o  (op_exc_o),
        .trap_o    (trap_o),
        .cause_o   (trap_cause_o)
    );

    // R11: the no-target selector touches no register
    a_r11_none_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd3 && !op_start_i && !op_end_i) |=>
            ($stable(flags_o) && $stable(enables_o) && $stable(rnd_mode_o)));

endmodule

// File: tb/fpsu_top_bench.sv
`timescale 1ns/1ps
module fpsu_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start_i = 1'b0, op_end_i = 1'b0;
    logic [4:0] op_exc_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = 2'd3;
    logic [4:0] wr_data_i = '0;
    logic [1:0] rnd_mode_o;
    logic [3:0] rnd_onehot_o;
    logic       op_busy_o, trap_o;
    logic [4:0] op_exc_o, flags_o, enables_o, trap_cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpsu_top u_fpsu_top (
        .clk(clk), .rst_n(rst_n), .op_start_i(op_start_i), .op_end_i(op_end_i),
        .op_exc_i(op_exc_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rnd_mode_o(rnd_mode_o), .rnd_onehot_o(rnd_onehot_o), .op_busy_o(op_busy_o),
        .op_exc_o(op_exc_o), .flags_o(flags_o), .enables_o(enables_o),
        .trap_o(trap_o), .trap_cause_o(trap_cause_o)
    );

    // {preload flags, enables, raised, expected flags, expected cause}
    localparam logic [24:0] VEC [8] = '{
        {5'b00000, 5'b00000, 5'b00001, 5'b00001, 5'b00000},
        {5'b00000, 5'b11111, 5'b00100, 5'b00100, 5'b00100},
        {5'b00100, 5'b11111, 5'b00100, 5'b00100, 5'b00000},
        {5'b00010, 5'b00110, 5'b00110, 5'b00110, 5'b00100},
        {5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000},
        {5'b10101, 5'b11111, 5'b00000, 5'b10101, 5'b00000},
        {5'b00000, 5'b01010, 5'b11111, 5'b11111, 5'b01010},
        {5'b01000, 5'b11000, 5'b11000, 5'b11000, 5'b10000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [4:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0; wr_sel_i = 2'd3;
    endtask

    task automatic op_launch();
        @(negedge clk);
        op_start_i = 1'b1;
        @(negedge clk);
        op_start_i = 1'b0;
    endtask

    // end strobe with optional same-cycle flag write; returns at the negedge after
    task automatic op_retire(input logic [4:0] exc, input bit race, input logic [4:0] wdata);
        op_end_i = 1'b1; op_exc_i = exc;
        if (race) begin
            wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = wdata;
        end
        @(negedge clk);
        op_end_i = 1'b0; op_exc_i = '0; wr_en_i = 1'b0; wr_sel_i = 2'd3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", flags_o, 0);
        chk("R1 enables", enables_o, 0);
        chk("R1 mode", rnd_mode_o, 0);
        chk("R1 onehot", rnd_onehot_o, 4'b0001);
        chk("R1 trap", trap_o, 0);
        chk("R1 cause", trap_cause_o, 0);
        chk("R1 record", op_exc_o, 0);
        chk("R1 busy", op_busy_o, 0);

        // R4 R5 R6 R7 R8: table walk
        for (int i = 0; i < 8; i++) begin
            reg_write(2'd1, VEC[i][24:20]);
            reg_write(2'd2, VEC[i][19:15]);
            chk("R11 enables write", enables_o, VEC[i][19:15]);
            op_launch();
            op_retire(VEC[i][14:10], 1'b0, '0);
            chk("R4 R6 R7 flags", flags_o, VEC[i][9:5]);
            chk("R5 cause", trap_cause_o, VEC[i][4:0]);
            chk("R5 R8 trap", trap_o, VEC[i][4:0] != 0);
            chk("R3 record", op_exc_o, VEC[i][14:10]);
            @(negedge clk);
            chk("R8 pulse ends", trap_o, 0);
        end

        // R2 rounding encodings
        for (int m = 0; m < 4; m++) begin
            reg_write(2'd0, 5'(m));
            chk("R11 mode write", rnd_mode_o, m);
            op_launch();
            chk("R2 onehot", rnd_onehot_o, 32'(4'b0001 << m));
            op_retire('0, 1'b0, '0);
        end
        // R2 mid-operation write does not move the select (mode 3 active)
        op_launch();
        reg_write(2'd0, 5'd1);
        chk("R2 held", rnd_onehot_o, 4'b1000);
        chk("R2 field updated", rnd_mode_o, 1);
        op_retire('0, 1'b0, '0);
        op_launch();
        chk("R2 relaunch", rnd_onehot_o, 4'b0010);

        // R3 record cleared at launch
        op_retire(5'b10101, 1'b0, '0);
        chk("R3 record loaded", op_exc_o, 5'b10101);
        op_launch();
        chk("R3 record cleared", op_exc_o, 0);
        op_retire('0, 1'b0, '0);

        // R10 end while idle ignored
        reg_write(2'd1, 5'b00000);
        reg_write(2'd2, 5'b11111);
        op_retire(5'b11111, 1'b0, '0);
        chk("R10 idle end flags", flags_o, 0);
        chk("R10 idle end trap", trap_o, 0);
        chk("R10 idle end record", op_exc_o, 0);
        // R10 start while busy ignored: still busy, record kept
        op_launch();
        op_retire(5'b00000, 1'b0, '0);
        op_launch();
        @(negedge clk); op_start_i = 1'b1; @(negedge clk); op_start_i = 1'b0;
        chk("R10 busy start", op_busy_o, 1);
        op_retire(5'b00001, 1'b0, '0);
        chk("R10 closed", op_busy_o, 0);
        chk("R5 after busy start", trap_o, 1);

        // R9 write wins over same-cycle merge
        reg_write(2'd1, 5'b00000);
        op_launch();
        op_retire(5'b00011, 1'b1, 5'b10000);
        chk("R9 flags", flags_o, 5'b10000);
        chk("R9 no trap", trap_o, 0);

        // R11 selector 3 writes nothing
        reg_write(2'd3, 5'b01111);
        chk("R11 none flags", flags_o, 5'b10000);
        chk("R11 none enables", enables_o, 5'b11111);
        chk("R11 none mode", rnd_mode_o, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule